// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the front end of a synchronous SRAM with a four-byte data path. Every control input is taken on the rising clock edge. A processor-side strobe or a controller-side strobe opens an access, but only when all three chip selects are active. The first address is registered, and a two-bit burst sequencer then produces the low address bits for the later beats. Those beats follow a linear or an XOR-interleaved order. Each beat becomes either a read or a byte-masked write to a behavioural array held inside the block.

The data bus is split into an input lane, an output lane and an output-enable. A pad ring or a bench joins the three into a tristate bus. A write opened by the processor strobe takes its write controls and data on the edge after the address. A write opened by the controller strobe is carried out on the same edge as the address. Read data leaves the block one clock after its beat and is driven only while the asynchronous output enable is low. An edge that carries a write always leaves the bus undriven.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An access opens only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 on the same edge as an active strobe. If a strobe is active while any select is inactive, the edge ends the current burst, and later edges without a strobe neither read nor write.
- R2: With `sel_a_n`=1, a low `cpu_strb_n` is ignored. Such an edge acts as a plain continuation of the running burst.
- R3: With `cpu_strb_n`=0, a low `mc_strb_n` is ignored: the edge opens a processor-strobe access, and no write happens on it.
- R4: On the edge that opens a processor-strobe access, the write controls are ignored. If the next edge presents write controls without an advance, `dq_i` from that edge is written at the opening address.
- R5: An edge that opens a controller-strobe access with write controls active writes `dq_i` at `addr_i` on that same edge.
- R6: A controller-strobe access with no write control active is a read. Its data is on `dq_o` after the following edge.
- R7: `all_wr_n`=0 writes all four bytes, whatever `lane_wr_n` and `lane_sel_n` are.
- R8: With `all_wr_n`=1, byte i (bits 8i+7..8i) is written only when `lane_wr_n`=0 and `lane_sel_n[i]`=0. With `lane_wr_n`=1 the edge is a read.
- R9: After any edge that performs a write, `dq_oe` is 0, even with `drive_en_n`=0.
- R10: `dq_oe` is 1 only while `drive_en_n` is 0 and read data from the previous edge is held. It follows `drive_en_n` without waiting for a clock.
- R11: With `xor_order`=0 on the opening edge, the k-th beat of a burst (k=0..3, counted over advances) uses low bits (base+k) mod 4. The upper address bits are held from the opening address, and the order stays fixed even if `xor_order` changes later.
- R12: With `xor_order`=1 on the opening edge, the k-th beat uses low bits base XOR k.
- R13: A continuation edge with `step_n`=1 repeats the current beat address. With `step_n`=0 it moves to the next address in the order, wrapping after four beats.
- R14: While `rst_n` is low and after it rises, no access is open and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | Word address taken on opening edges |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| mc_strb_n | input | 1 | Controller-side address strobe, active low |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write of all bytes, active low |
| lane_wr_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | NB | Per-byte write selects, active low |
| drive_en_n | input | 1 | Asynchronous output enable, active low |
| xor_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_i | input | NB*BW | Write data lane |
| dq_o | output | NB*BW | Read data lane |
| dq_oe | output | 1 | Output-enable for the data bus |

## Verification
Writes land on the edge that carries them. A read beat on edge n puts its word on `dq_o` after edge n+1. `dq_oe` follows `drive_en_n` within the same cycle. The bench changes inputs on falling edges and samples outputs on the next falling edge, so every sample shows exactly one rising edge of effect. The expected word for a sample is always the word addressed by the beat one edge earlier. Burst addresses are computed in the bench from the opening address, the order bit and the count of advances. Writes are confirmed by reading the words back in a later access.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // Classification of one clock edge by the strobe and select inputs
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_DESEL  = 2'd1,
        EV_PSTART = 2'd2,
        EV_CSTART = 2'd3
    } strobe_ev_e;

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
    import burst_sram_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          cpu_strb_n,
    input  logic          mc_strb_n,
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          all_wr_n,
    input  logic          lane_wr_n,
    input  logic [NB-1:0] lane_sel_n,
    output strobe_ev_e    ev_o,
    output logic          wr_req_o,
    output logic [NB-1:0] wmask_o
);

    logic cs_all;
    logic cpu_seen;
    logic mc_seen;

    always_comb begin
        cs_all   = !sel_a_n && sel_b && !sel_c_n;
        // processor strobe only counts while the first select is active
        cpu_seen = !cpu_strb_n && !sel_a_n;
        // controller strobe only counts while the processor strobe is high
        mc_seen  = !mc_strb_n && cpu_strb_n;

        if (cpu_seen) begin
            ev_o = cs_all ? EV_PSTART : EV_DESEL;
        end else if (mc_seen) begin
            ev_o = cs_all ? EV_CSTART : EV_DESEL;
        end else begin
            ev_o = EV_IDLE;
        end

        if (!all_wr_n) begin
            wmask_o = '1;
        end else if (!lane_wr_n) begin
            wmask_o = ~lane_sel_n;
        end else begin
            wmask_o = '0;
        end
        wr_req_o = |wmask_o;
    end

    always_comb begin
        if (ev_o == EV_PSTART) begin
            // R2
            cpu_gate_chk: assert (!sel_a_n);
        end
        if (ev_o == EV_CSTART) begin
            // R3
            mc_gate_chk: assert (cpu_strb_n);
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          il_i,
    input  logic [CW-1:0] base_i,
    output logic [CW-1:0] cur_o
);

    typedef struct packed {
        logic [CW-1:0] base;
        logic [CW-1:0] cnt;
        logic          il;
    } seq_t;

    seq_t st_d, st_q;

    function automatic logic [CW-1:0] order_f(input logic il,
                                              input logic [CW-1:0] b,
                                              input logic [CW-1:0] k);
        return il ? (b ^ k) : (b + k);
    endfunction

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base = base_i;
            st_d.cnt  = '0;
            st_d.il   = il_i;
            cur_o     = base_i;
        end else if (step_i) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            cur_o     = order_f(st_q.il, st_q.base, st_q.cnt + 1'b1);
        end else begin
            cur_o     = order_f(st_q.il, st_q.base, st_q.cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(st_q));

    // R11
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (load_i || step_i || cur_o == $past(base_i)));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [NB-1:0]    wmask_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [NB*BW-1:0] wdata_i,
    input  logic             re_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [NB*BW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];
        logic [BW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (we_i && wmask_i[b]) begin
                lane_mem[waddr_i] <= wdata_i[b*BW +: BW];
            end
        end

        always_ff @(posedge clk) begin
            if (re_i) begin
                lane_q <= lane_mem[raddr_i];
            end
        end

        assign rdata_o[b*BW +: BW] = lane_q;
    end

    // R8
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (wmask_i != '0));

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             cpu_strb_n,
    input  logic             mc_strb_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [NB-1:0]    lane_sel_n,
    input  logic             drive_en_n,
    input  logic             xor_order,
    input  logic [NB*BW-1:0] dq_i,
    output logic [NB*BW-1:0] dq_o,
    output logic             dq_oe
);

    localparam int DW   = NB * BW;
    localparam int HI_W = AW - CW;

    typedef struct packed {
        logic            active;
        logic [HI_W-1:0] hi;
        logic            rd_pend;
        logic [AW-1:0]   rd_addr;
        logic            dout_vld;
    } ctl_t;

    ctl_t st_d, st_q;

    strobe_ev_e    ev;
    logic          wr_req;
    logic [NB-1:0] wmask;
    logic [CW-1:0] cur_low;
    logic          beat_start;
    logic          beat_cont;
    logic          beat_wr;
    logic          beat_rd;
    logic          seq_step;
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] rdata;

    strobe_decode #(.NB(NB)) u_dec (
        .cpu_strb_n (cpu_strb_n),
        .mc_strb_n  (mc_strb_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .ev_o       (ev),
        .wr_req_o   (wr_req),
        .wmask_o    (wmask)
    );

    burst_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (beat_start),
        .step_i (seq_step),
        .il_i   (xor_order),
        .base_i (addr_i[CW-1:0]),
        .cur_o  (cur_low)
    );

    sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (beat_wr),
        .wmask_i (wmask),
        .waddr_i (beat_addr),
        .wdata_i (dq_i),
        .re_i    (st_q.rd_pend),
        .raddr_i (st_q.rd_addr),
        .rdata_o (rdata)
    );

    always_comb begin
        st_d = st_q;

        beat_start = (ev == EV_PSTART) || (ev == EV_CSTART);
        beat_cont  = (ev == EV_IDLE) && st_q.active;
        seq_step   = beat_cont && !step_n;

        // processor-strobe opening edges never write
        beat_wr = ((ev == EV_CSTART) || beat_cont) && wr_req;
        beat_rd = (beat_start || beat_cont) && !beat_wr;

        beat_addr = beat_start ? addr_i : {st_q.hi, cur_low};

        if (beat_start) begin
            st_d.active = 1'b1;
            st_d.hi     = addr_i[AW-1:CW];
        end else if (ev == EV_DESEL) begin
            st_d.active = 1'b0;
        end

        st_d.rd_pend  = beat_rd;
        st_d.rd_addr  = beat_addr;
        // a write edge squashes the word read for the previous beat
        st_d.dout_vld = st_q.rd_pend && !beat_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o  = rdata;
    assign dq_oe = st_q.dout_vld && !drive_en_n;

    // R9
    wr_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_wr |=> !dq_oe);

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_DESEL) |=> !((ev == EV_IDLE) && beat_wr));

endmodule

// File: tb/tb_burst_sram_ctrl.sv
module tb_burst_sram_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        cpu = 1'b1, mc = 1'b1, sa = 1'b0, sb = 1'b1, sc = 1'b0;
    logic        stp = 1'b1, aw = 1'b1, lw = 1'b1, den = 1'b0, xo = 1'b0;
    logic [3:0]  sel = 4'hF;
    logic [31:0] din = 32'h0;
    logic [31:0] dq_o;
    logic        dq_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    burst_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .cpu_strb_n(cpu), .mc_strb_n(mc),
        .sel_a_n(sa), .sel_b(sb), .sel_c_n(sc),
        .step_n(stp), .all_wr_n(aw), .lane_wr_n(lw), .lane_sel_n(sel),
        .drive_en_n(den), .xor_order(xo),
        .dq_i(din), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // ctl bits: cpu mc sa sb sc step all lane sel[3:0] den
    typedef struct packed {
        logic [7:0]  addr;
        logic [12:0] ctl;
        logic [31:0] din;
        logic        chk;
        logic        eoe;
        logic [31:0] edq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{8'h10, 13'b1_0_0_1_0_1_0_1_1111_0, 32'hAAAA0001, 1'b1, 1'b0, 32'h0, 4'd5},        // R5
        '{8'h10, 13'b1_0_0_0_0_1_1_1_1111_0, 32'h0,        1'b0, 1'b0, 32'h0, 4'd1},        // R1
        '{8'h10, 13'b1_0_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b0, 32'h0, 4'd6},        // R6
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'hAAAA0001, 4'd7}, // R7
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_1, 32'h0,        1'b1, 1'b0, 32'h0, 4'd10},       // R10
        '{8'h10, 13'b1_0_0_1_0_1_1_0_1010_0, 32'h11223344, 1'b1, 1'b0, 32'h0, 4'd9},        // R9
        '{8'h00, 13'b1_1_0_1_0_1_1_1_0000_0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0, 4'd8},        // R8
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'hAA220044, 4'd8}, // R8
        '{8'h20, 13'b0_1_0_1_0_1_0_1_1111_0, 32'hDEADBEEF, 1'b1, 1'b1, 32'hAA220044, 4'd13},// R13
        '{8'h00, 13'b1_1_0_1_0_1_0_1_1111_0, 32'h5555AAAA, 1'b1, 1'b0, 32'h0, 4'd9},        // R9
        '{8'h20, 13'b1_0_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b0, 32'h0, 4'd6},        // R6
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'h5555AAAA, 4'd4}, // R4
        '{8'h10, 13'b0_0_0_1_0_1_0_1_1111_0, 32'h0BADF00D, 1'b0, 1'b0, 32'h0, 4'd3},        // R3
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'hAA220044, 4'd3}, // R3
        '{8'h00, 13'b0_1_1_1_0_1_1_1_1111_0, 32'h0,        1'b0, 1'b0, 32'h0, 4'd2},        // R2
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'hAA220044, 4'd2}, // R2
        '{8'h00, 13'b0_1_0_1_1_1_1_1_1111_0, 32'h0,        1'b0, 1'b0, 32'h0, 4'd1},        // R1
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b0, 32'h0, 4'd1},        // R1
        '{8'h20, 13'b1_0_0_1_1_1_0_1_1111_0, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0, 4'd1},        // R1
        '{8'h20, 13'b1_0_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b0, 32'h0, 4'd6},        // R6
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b1, 32'h5555AAAA, 4'd1}, // R1
        '{8'h00, 13'b1_0_0_0_0_1_1_1_1111_0, 32'h0,        1'b0, 1'b0, 32'h0, 4'd1},        // R1
        '{8'h00, 13'b1_1_0_1_0_1_1_1_1111_0, 32'h0,        1'b1, 1'b0, 32'h0, 4'd1}         // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        addr = 8'h00; cpu = 1'b1; mc = 1'b1; sa = 1'b0; sb = 1'b1; sc = 1'b0;
        stp = 1'b1; aw = 1'b1; lw = 1'b1; sel = 4'hF; den = 1'b0; din = 32'h0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [1:0] ord(input logic m, input logic [1:0] b, input int k);
        logic [1:0] kk;
        kk = k[1:0];
        return m ? (b ^ kk) : (b + kk);
    endfunction

    function automatic logic [31:0] vpat(input logic m, input logic [1:0] b, input logic [7:0] a);
        return {8'h5A, 7'd0, m, 6'd0, b, a};
    endfunction

    task automatic burst_case(input logic m, input logic [1:0] b);
        logic [7:0] hi;
        string tag;
        hi  = m ? 8'h80 : 8'h40;
        tag = m ? "R12" : "R11";
        // burst write opened by the controller strobe
        idle(); mc = 1'b0; addr = hi | {6'd0, b}; aw = 1'b0; xo = m;
        din = vpat(m, b, hi | {6'd0, ord(m, b, 0)});
        tick();
        for (int k = 1; k < 4; k++) begin
            idle(); stp = 1'b0; aw = 1'b0; xo = !m;
            din = vpat(m, b, hi | {6'd0, ord(m, b, k)});
            tick();
        end
        idle(); mc = 1'b0; sb = 1'b0; tick();
        // single reads at explicit addresses
        for (int k = 0; k < 4; k++) begin
            idle(); mc = 1'b0; addr = hi | k[7:0]; tick();
            idle(); tick();
            check(tag, {31'd0, dq_oe}, 32'd1);
            check(tag, dq_o, vpat(m, b, hi | k[7:0]));
        end
        idle(); mc = 1'b0; sb = 1'b0; tick();
        // burst read opened by the processor strobe
        idle(); cpu = 1'b0; addr = hi | {6'd0, b}; xo = m; tick();
        idle(); stp = 1'b0; xo = !m; tick();
        check(tag, dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 0)}));
        idle(); xo = !m; tick();
        check(tag, dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 1)}));
        idle(); stp = 1'b0; xo = !m; tick();
        check("R13", dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 1)}));
        idle(); stp = 1'b0; tick();
        check(tag, dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 2)}));
        idle(); stp = 1'b0; tick();
        check(tag, dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 3)}));
        idle(); mc = 1'b0; sb = 1'b0; tick();
        check("R13", dq_o, vpat(m, b, hi | {6'd0, ord(m, b, 0)}));
        idle(); tick();
        check("R1", {31'd0, dq_oe}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        check("R14", {31'd0, dq_oe}, 32'd0);
        rst_n = 1'b1;
        tick();
        check("R14", {31'd0, dq_oe}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            addr = VEC[i].addr;
            {cpu, mc, sa, sb, sc, stp, aw, lw, sel, den} = VEC[i].ctl;
            din = VEC[i].din;
            tick();
            if (VEC[i].chk) begin
                check($sformatf("R%0d", VEC[i].req), {31'd0, dq_oe}, {31'd0, VEC[i].eoe});
                if (VEC[i].eoe) begin
                    check($sformatf("R%0d", VEC[i].req), dq_o, VEC[i].edq);
                end
            end
        end

        // R10: enable follows drive_en_n without a clock edge
        idle(); mc = 1'b0; addr = 8'h10; tick();
        idle(); tick();
        check("R10", {31'd0, dq_oe}, 32'd1);
        #1 den = 1'b1; #1;
        check("R10", {31'd0, dq_oe}, 32'd0);
        den = 1'b0; #1;
        check("R10", {31'd0, dq_oe}, 32'd1);

        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) begin
                burst_case(m[0], b[1:0]);
            end
        end

        // R14: reset in the middle of a read burst
        idle(); mc = 1'b0; addr = 8'h10; tick();
        idle(); tick();
        check("R14", {31'd0, dq_oe}, 32'd1);
        idle(); rst_n = 1'b0; tick();
        check("R14", {31'd0, dq_oe}, 32'd0);
        rst_n = 1'b1; idle(); tick();
        idle(); tick();
        check("R14", {31'd0, dq_oe}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule